// File: doc/BRIEF.md
# Pipelined Processor Local Bus Sequencer

This block is the bus master side of a 16-bit processor local bus. It runs from a system clock at twice the processor rate and divides it into a processor clock of two phases. The first system clock of each processor clock is phase 1 and the second is phase 2. A phase output shows which phase comes next. Every bus state lasts exactly one processor clock, and the state only changes at the end of phase 2.

A requester hands over one operation at a time through a valid/ready port. An operation carries a type, an address, a byte/word flag and write data. The sequencer keeps a one-entry queue. It runs each operation through send-status and then one or more perform-command clocks, and it inserts wait states until the ready input is seen high. For read-type operations it steers the captured read data into a done pulse.

While the current operation is still in perform-command, the sequencer already drives the address of the queued operation. That operation's send-status then follows on the very next processor clock. An external master can take the bus through a hold request. While the bus is held, the address, data and status outputs are released, and an acknowledge output is raised. Decoding the status into command strobes is left to the logic outside this block.

Top module: `lbus_seq`

## Requirements
- R1: The phase output `ph_next1` toggles on every system clock. It is 0 during phase 1 and 1 during phase 2. The first system clock after reset is phase 1. The status lines change only when a new phase 1 begins.
- R2: After reset, `stat_n` is 2'b11 and `hlda` and `done` are 0. `req_ready` is 1, because the queue is empty.
- R3: Send-status lasts one processor clock and starts at phase 1. In that clock `stat_n` is 2'b10 for the read-type operations (memory read, I/O read, interrupt acknowledge) and 2'b01 for the others. Outside send-status, `stat_n` is 2'b11. Both lines are never low together.
- R4: The operation codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge and 5 halt. Codes 6 and 7 behave as halt. During send-status, `mio` is 1 only for the memory operations, and `ack` is 1 only for interrupt acknowledge and halt.
- R5: Perform-command repeats while `rdy` is low at the end of its phase 2. For an operation with w wait states, `done` is a one-system-clock pulse that appears 2+2(w+1) system clocks after the first clock of send-status.
- R6: A byte at an even address gives `a0`=0 and `bhe_n`=1. A byte at an odd address gives `a0`=1 and `bhe_n`=0. A word gives `a0`=0 and `bhe_n`=0. `addr_hi` carries address bits 23..1.
- R7: For I/O operations, the address bits above bit 15 are driven as 0. Interrupt acknowledge is always driven as an even byte on the lower lane (`a0`=0, `bhe_n`=1).
- R8: The read data in `done_rdata` follows these rules:
  - A word read returns `rdata_in` unchanged.
  - An even byte read returns the lower lane zero-extended.
  - An odd byte read returns the upper lane, moved to bits 7..0 and zero-extended.
  - Interrupt acknowledge returns the lower lane.
  - Non-read operations return 0.
- R9: For memory or I/O writes, `wdata_oe` is 1 during send-status and perform-command. `wdata_out` is the word unchanged for a word write, and the low byte copied onto both lanes for a byte write.
- R10: An operation queued while the current one is in perform-command has its address, `a0` and `bhe_n` driven during that perform-command. Its send-status begins in the processor clock right after the current operation completes.
- R11: If nothing is queued when an operation completes, the bus returns to idle with `stat_n`=2'b11.
- R12: `hold` is sampled only while idle or at the completion of an operation, so an operation in progress always finishes first. In hold, `hlda` is 1 and `bus_oe` is 0. The bus returns to idle, with `hlda`=0, one processor clock after `hold` is seen low at the end of a phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (double frequency) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue slot free; request taken on a clock with valid |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Byte address |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_wdata | input | DW | Write data (byte in bits 7..0) |
| done | output | 1 | Operation completed (one system clock) |
| done_rdata | output | DW | Lane-steered read data |
| ph_next1 | output | 1 | 1 when the next system clock is phase 1 |
| stat_n | output | 2 | Active-low status lines |
| mio | output | 1 | Memory (1) or I/O (0) operation |
| ack | output | 1 | Interrupt acknowledge or halt |
| addr_hi | output | AW-1 | Address bits AW-1..1 |
| a0 | output | 1 | Address bit 0 |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| bus_oe | output | 1 | Address and status drivers enabled |
| wdata_out | output | DW | Write data on the bus |
| wdata_oe | output | 1 | Write data drivers enabled |
| rdata_in | input | DW | Read data from the bus |
| rdy | input | 1 | Device ready, sampled at the end of perform-command |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus handed over |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 16-bit data bus and a 16-bit I/O space. With these values, the I/O masking of bits 23..16 is visible, and so are both byte lanes. Random addresses over the full 24 bits, random op codes including 6 and 7, and zero to three wait states cover the lane and status combinations. Directed cases cover queuing during perform-command, hold while idle, and hold raised in the middle of an operation.

// File: rtl/lbus_seq.sv
module lbus_seq #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int IOW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          ph_next1,
  output logic [1:0]    stat_n,
  output logic          mio,
  output logic          ack,
  output logic [AW-1:1] addr_hi,
  output logic          a0,
  output logic          bhe_n,
  output logic          bus_oe,
  output logic [DW-1:0] wdata_out,
  output logic          wdata_oe,
  input  logic [DW-1:0] rdata_in,
  input  logic          rdy,
  input  logic          hold,
  output logic          hlda
);
  localparam int BW = DW / 2;
  localparam logic [2:0] OP_MRD = 3'd0, OP_MWR = 3'd1, OP_IORD = 3'd2,
                         OP_IOWR = 3'd3, OP_INTA = 3'd4, OP_HALT = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_TS, S_TC, S_HOLD} bstate_t;

  function automatic logic [2:0] norm_op(input logic [2:0] o);
    return (o > OP_HALT) ? OP_HALT : o;
  endfunction

  function automatic logic is_rd(input logic [2:0] o);
    return (o == OP_MRD) || (o == OP_IORD) || (o == OP_INTA);
  endfunction

  bstate_t        st;
  logic           ph;
  logic [2:0]     cur_op,   nq_op;
  logic [AW-1:0]  cur_addr, nq_addr;
  logic           cur_word, nq_word;
  logic [DW-1:0]  cur_wd,   nq_wd;
  logic           nq_v;

  wire bnd    = ph;
  wire sel_nq = (st == S_TC) && nq_v;

  wire [2:0]    sel_op   = sel_nq ? nq_op   : cur_op;
  wire [AW-1:0] sel_addr = sel_nq ? nq_addr : cur_addr;
  wire          sel_word = sel_nq ? nq_word : cur_word;

  wire is_io   = (sel_op == OP_IORD) || (sel_op == OP_IOWR);
  wire is_inta = (sel_op == OP_INTA);

  logic [AW-1:0] eff_addr;
  assign eff_addr = is_io ? {{(AW-IOW){1'b0}}, sel_addr[IOW-1:0]} : sel_addr;

  assign addr_hi  = eff_addr[AW-1:1];
  assign a0       = is_inta ? 1'b0 : (sel_word ? 1'b0 : eff_addr[0]);
  assign bhe_n    = is_inta ? 1'b1 : (sel_word ? 1'b0 : ~eff_addr[0]);
  assign mio      = (sel_op == OP_MRD) || (sel_op == OP_MWR);
  assign ack      = (sel_op == OP_INTA) || (sel_op == OP_HALT);

  assign stat_n   = (st == S_TS) ? (is_rd(cur_op) ? 2'b10 : 2'b01) : 2'b11;
  assign bus_oe   = (st != S_HOLD);
  assign hlda     = (st == S_HOLD);
  assign ph_next1 = ph;
  assign req_ready = !nq_v;

  assign wdata_oe  = ((st == S_TS) || (st == S_TC)) &&
                     ((cur_op == OP_MWR) || (cur_op == OP_IOWR));
  assign wdata_out = cur_word ? cur_wd : {cur_wd[BW-1:0], cur_wd[BW-1:0]};

  logic [DW-1:0] cap;
  always_comb begin
    if (cur_word && cur_op != OP_INTA)
      cap = rdata_in;
    else if (cur_op == OP_INTA || !cur_addr[0])
      cap = {{BW{1'b0}}, rdata_in[BW-1:0]};
    else
      cap = {{BW{1'b0}}, rdata_in[DW-1:BW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= 1'b0;
      st         <= S_IDLE;
      done       <= 1'b0;
      done_rdata <= '0;
      nq_v       <= 1'b0;
      nq_op      <= '0;
      nq_addr    <= '0;
      nq_word    <= 1'b0;
      nq_wd      <= '0;
      cur_op     <= OP_HALT;
      cur_addr   <= '0;
      cur_word   <= 1'b0;
      cur_wd     <= '0;
    end else begin
      ph   <= ~ph;
      done <= 1'b0;
      if (req_valid && !nq_v) begin
        nq_v    <= 1'b1;
        nq_op   <= norm_op(req_op);
        nq_addr <= req_addr;
        nq_word <= req_word;
        nq_wd   <= req_wdata;
      end
      if (bnd) begin
        unique case (st)
          S_IDLE: begin
            if (hold) st <= S_HOLD;
            else if (nq_v) begin
              st       <= S_TS;
              cur_op   <= nq_op;
              cur_addr <= nq_addr;
              cur_word <= nq_word;
              cur_wd   <= nq_wd;
              nq_v     <= 1'b0;
            end
          end
          S_TS: st <= S_TC;
          S_TC: begin
            if (rdy) begin
              done       <= 1'b1;
              done_rdata <= is_rd(cur_op) ? cap : '0;
              if (hold) st <= S_HOLD;
              else if (nq_v) begin
                st       <= S_TS;
                cur_op   <= nq_op;
                cur_addr <= nq_addr;
                cur_word <= nq_word;
                cur_wd   <= nq_wd;
                nq_v     <= 1'b0;
              end else st <= S_IDLE;
            end
          end
          S_HOLD: if (!hold) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module lbus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ph_next1,
  input logic [1:0] stat_n,
  input logic       done,
  input logic       rdy,
  input logic       hold,
  input logic       hlda,
  input logic       bus_oe
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R1
  ph_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ph_next1 != $past(ph_next1));

  // R1
  stat_on_phase1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && stat_n != $past(stat_n)) |-> !ph_next1);

  // R3
  stat_never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_n != 2'b00);

  // R5
  done_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && done) |-> $past(rdy));

  // R12
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && stat_n == 2'b11));

  // R12
  hlda_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(hlda)) |-> $past(hold));
endmodule

bind lbus_seq lbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph_next1(ph_next1), .stat_n(stat_n),
  .done(done), .rdy(rdy), .hold(hold), .hlda(hlda), .bus_oe(bus_oe)
);

// File: tb/lbus_seq_test.sv
module lbus_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [2:0]  req_op = 0;
  logic [23:0] req_addr = 0;
  logic        req_word = 0;
  logic [15:0] req_wdata = 0;
  logic        done;
  logic [15:0] done_rdata;
  logic        ph_next1;
  logic [1:0]  stat_n;
  logic        mio, ack, a0, bhe_n, bus_oe, wdata_oe, hlda;
  logic [23:1] addr_hi;
  logic [15:0] wdata_out;
  logic [15:0] rdata_in = 0;
  logic        rdy = 0;
  logic        hold = 0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_word(req_word),
    .req_wdata(req_wdata), .done(done), .done_rdata(done_rdata),
    .ph_next1(ph_next1), .stat_n(stat_n), .mio(mio), .ack(ack),
    .addr_hi(addr_hi), .a0(a0), .bhe_n(bhe_n), .bus_oe(bus_oe),
    .wdata_out(wdata_out), .wdata_oe(wdata_oe), .rdata_in(rdata_in),
    .rdy(rdy), .hold(hold), .hlda(hlda)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] e_op(input logic [2:0] o);
    return (o > 3'd5) ? 3'd5 : o;
  endfunction
  function automatic bit e_rd(input logic [2:0] o);
    return o == 0 || o == 2 || o == 4;
  endfunction
  function automatic logic [23:0] e_addr(input logic [2:0] o, input logic [23:0] ad);
    return (o == 2 || o == 3) ? {8'h00, ad[15:0]} : ad;
  endfunction
  function automatic logic [1:0] e_lanes(input logic [2:0] o, input logic [23:0] ad, input bit w);
    if (o == 4) return 2'b01;
    if (w) return 2'b00;
    return ad[0] ? 2'b10 : 2'b01;
  endfunction
  function automatic logic [15:0] e_rdata(input logic [2:0] o, input logic [23:0] ad, input bit w, input logic [15:0] rd);
    if (!e_rd(o)) return 16'h0;
    if (o == 4) return {8'h0, rd[7:0]};
    if (w) return rd;
    return ad[0] ? {8'h0, rd[15:8]} : {8'h0, rd[7:0]};
  endfunction

  task automatic issue(input logic [2:0] op, input logic [23:0] ad, input bit w, input logic [15:0] wd);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = ad; req_word = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_ts();
    for (int i = 0; i < 30 && stat_n == 2'b11; i++) @(negedge clk);
    chk(stat_n != 2'b11, "R3 send-status reached", stat_n, 2'b10);
  endtask

  task automatic check_addr(input string req, input logic [2:0] op, input logic [23:0] ad, input bit w);
    logic [2:0] o;
    logic [23:0] ea;
    o = e_op(op);
    ea = e_addr(o, ad);
    chk(addr_hi == ea[23:1], {req, " addr"}, {9'h0, addr_hi}, {9'h0, ea[23:1]});
    chk({a0, bhe_n} == e_lanes(o, ea, w), {req, " R6 a0/bhe_n"}, {a0, bhe_n}, e_lanes(o, ea, w));
  endtask

  task automatic check_ts(input logic [2:0] op, input logic [23:0] ad, input bit w, input logic [15:0] wd);
    logic [2:0] o;
    o = e_op(op);
    chk(stat_n == (e_rd(o) ? 2'b10 : 2'b01), "R3 status code", stat_n, e_rd(o) ? 2'b10 : 2'b01);
    chk(!ph_next1, "R1 send-status starts in phase 1", ph_next1, 0);
    chk(mio == (o <= 1) && ack == (o >= 4), "R4 mio/ack", {mio, ack}, {o <= 1, o >= 4});
    check_addr("R7", op, ad, w);
    chk(wdata_oe == (o == 1 || o == 3), "R9 wdata_oe", wdata_oe, o == 1 || o == 3);
    if (o == 1 || o == 3)
      chk(wdata_out == (w ? wd : {wd[7:0], wd[7:0]}), "R9 wdata", wdata_out, w ? wd : {wd[7:0], wd[7:0]});
  endtask

  task automatic finish_op(input logic [2:0] op, input logic [23:0] ad, input bit w, input logic [15:0] rd, input int waits, input bit expect_idle);
    int n;
    n = 0;
    @(negedge clk); n++;
    @(negedge clk); n++;
    for (int k = 0; k <= waits; k++) begin
      rdy = (k == waits);
      chk(done == 0 && stat_n == 2'b11, "R5 no done during wait", {done, stat_n}, 3'b011);
      @(negedge clk); n++;
      @(negedge clk); n++;
    end
    rdy = 0;
    chk(done == 1, "R5 done timing", n, 2 + 2 * (waits + 1));
    chk(done_rdata == e_rdata(e_op(op), ad, w, rd), "R8 read data", done_rdata, e_rdata(e_op(op), ad, w, rd));
    if (expect_idle) begin
      @(negedge clk);
      chk(done == 0 && stat_n == 2'b11, "R11 idle after completion", {done, stat_n}, 3'b011);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [23:0] ad, input bit w, input logic [15:0] wd, input logic [15:0] rd, input int waits);
    rdata_in = rd;
    issue(op, ad, w, wd);
    wait_ts();
    check_ts(op, ad, w, wd);
    finish_op(op, ad, w, rd, waits, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(stat_n == 2'b11 && !hlda && !done && req_ready, "R2 reset state",
        {stat_n, hlda, done, req_ready}, 5'b11001);
    chk(ph_next1 == 0, "R1 first clock is phase 1", ph_next1, 0);
    @(negedge clk);
    chk(ph_next1 == 1, "R1 phase toggles", ph_next1, 1);
    @(negedge clk);

    do_op(3'd0, 24'h12_3456, 1, 16'h0, 16'hBEEF, 0);
    do_op(3'd0, 24'h00_0011, 0, 16'h0, 16'hA55A, 1);
    do_op(3'd2, 24'hAB_CDE0, 0, 16'h0, 16'h7733, 2);
    do_op(3'd3, 24'hFF_0007, 0, 16'h00C3, 16'h0, 0);
    do_op(3'd1, 24'h40_0002, 1, 16'h1234, 16'h0, 3);
    do_op(3'd4, 24'h00_0003, 1, 16'h0, 16'h9C21, 0);
    do_op(3'd7, 24'h00_0002, 0, 16'h0, 16'hFFFF, 0);

    // R10 pipelined address and back-to-back send-status
    rdata_in = 16'h5A01;
    issue(3'd0, 24'h01_0000, 1, 16'h0);
    wait_ts();
    check_ts(3'd0, 24'h01_0000, 1, 16'h0);
    issue(3'd1, 24'h02_0005, 0, 16'h0066);
    @(negedge clk);
    rdy = 1;
    check_addr("R10 next address during perform-command", 3'd1, 24'h02_0005, 0);
    @(negedge clk);
    @(negedge clk);
    rdy = 0;
    chk(done == 1 && done_rdata == 16'h5A01, "R10 first completes", done_rdata, 16'h5A01);
    chk(stat_n == 2'b01, "R10 next send-status immediately", stat_n, 2'b01);
    check_ts(3'd1, 24'h02_0005, 0, 16'h0066);
    finish_op(3'd1, 24'h02_0005, 0, 16'h0, 0, 1);

    // R12 hold while idle
    hold = 1;
    repeat (4) @(negedge clk);
    chk(hlda && !bus_oe && stat_n == 2'b11, "R12 hold taken", {hlda, bus_oe, stat_n}, 4'b1011);
    repeat (2) @(negedge clk);
    while (ph_next1) @(negedge clk);
    @(negedge clk);
    hold = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!hlda && bus_oe, "R12 released one processor clock later", {hlda, bus_oe}, 2'b01);

    // R12 hold during an operation: finishes first, then hold
    rdata_in = 16'h3C3C;
    issue(3'd0, 24'h00_0100, 1, 16'h0);
    wait_ts();
    hold = 1;
    finish_op(3'd0, 24'h00_0100, 1, 16'h3C3C, 2, 0);
    chk(hlda == 1 && stat_n == 2'b11, "R12 hold after completion", {hlda, stat_n}, 3'b111);
    hold = 0;
    @(negedge clk);
    @(negedge clk);
    chk(hlda == 0, "R12 release timing", hlda, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      logic [23:0] ad;
      bit w;
      logic [15:0] wd, rd;
      op = 3'($urandom_range(0, 7));
      ad = 24'($urandom);
      w  = 1'($urandom_range(0, 1));
      wd = 16'($urandom);
      rd = 16'($urandom);
      do_op(op, ad, w, wd, rd, int'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule